// File: doc/BRIEF.md
# SPI Target Port with Receive Overrun Flag

This block is the serial-target side of an SPI link. An external controller supplies the serial clock and the target-input data line. The block returns data on the target-output line. The serial clock, the input data and the select line are brought into the local clock domain through synchronizers, and each serial-clock edge is found by comparing successive samples. No bit-rate generator exists inside the block: the controller's clock alone paces every character. The local clock is assumed to run at least four times faster than the serial clock.

On the host side there is a one-deep transmit holding buffer and a receive buffer, each with its own flag. A transmit-ready flag shows that the holding buffer may be written. A receive-ready flag shows that a fresh character is waiting. An overrun flag shows that a character was overwritten before the host read it. A character is 7 or 8 bits long and may travel most-significant or least-significant bit first. Clock polarity and clock phase are selectable. In the four-wire arrangement an active-low select input gates all activity. In the three-wire arrangement that input is ignored. A synchronous soft-reset input aborts any transfer and returns the host flags to their idle values.

Top module: `spi_target_ovr`

## Requirements
- R1: The leading edge is the serial-clock edge that leaves the idle level given by `cpol`. With `cpha`=0, input data is captured on leading edges, the first output bit is present before the first edge, and the output moves on trailing edges. With `cpha`=1, input data is captured on trailing edges and the output moves on leading edges, except the first leading edge of a character.
- R2: With `msb_first`=1, bit (length-1) of a character is sent and received first. With `msb_first`=0, bit 0 goes first.
- R3: With `char7`=1 a character has 7 bits. Only `tx_data[6:0]` is sent, and the received value sits in `rx_data[6:0]` with `rx_data[7]` equal to 0.
- R4: When a character completes, it is written to `rx_data` and `rx_ready` goes to 1. A one-cycle `rx_rd` pulse clears `rx_ready`.
- R5: If a character completes while `rx_ready` is still 1, `ovr_err` goes to 1 and `rx_data` takes the newer character. `ovr_err` stays set until an `rx_rd` pulse clears it.
- R6: A `tx_wr` pulse fills the holding buffer and drops `tx_ready`. The buffer moves into the shifter, and `tx_ready` returns to 1, only while no serial-clock edge of the current character has been seen. A write made after the first edge goes out in the following character.
- R7: If nothing new was written, the next character repeats the previously sent value.
- R8: With `four_pin`=1 and `ste_n` high, nothing is captured and `miso_oe` is 0. Raising `ste_n` in the middle of a character discards its partial bits.
- R9: With `four_pin`=0, `ste_n` has no effect: characters are exchanged and `miso_oe` is 1.
- R10: While `sw_rst` is 1, `rx_ready`, `ovr_err` and both interrupt enables clear, `tx_ready` is 1, and any transfer in progress is abandoned.
- R11: `ie_wr` loads the receive and transmit interrupt enables from `ie_rx_d` and `ie_tx_d`. `irq_rx` equals `rx_ready` AND the receive enable, and `irq_tx` equals `tx_ready` AND the transmit enable.
- R12: After reset, `tx_ready`=1, `rx_ready`=0, `ovr_err`=0, both interrupt outputs are 0, and with `four_pin`=1 and `ste_n` high, `miso_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Soft reset, holds the port idle while high |
| four_pin | input | 1 | 1 selects four-wire mode with select gating |
| msb_first | input | 1 | Bit order select |
| char7 | input | 1 | 1 selects 7-bit characters |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Capture on trailing edge when 1 |
| tx_wr | input | 1 | Write strobe for the transmit holding buffer |
| tx_data | input | DATA_W | Transmit character |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| ie_wr | input | 1 | Write strobe for the interrupt enables |
| ie_rx_d | input | 1 | Receive interrupt enable value |
| ie_tx_d | input | 1 | Transmit interrupt enable value |
| sclk | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data from the controller |
| ste_n | input | 1 | Active-low select |
| miso | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Drive enable for miso |
| rx_data | output | DATA_W | Receive buffer |
| rx_ready | output | 1 | Receive buffer holds an unread character |
| tx_ready | output | 1 | Holding buffer may be written |
| ovr_err | output | 1 | Receive overrun |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
A wrong bit or edge count inside the shifter does not fail at once. It shows one character later, as a shifted or rotated value on `rx_data` and at the controller's end of `miso`. A stale partial count after select is released does the same: it corrupts the next character. A stuck buffer flag appears within a cycle as `tx_ready` failing to return after a write, or as `ovr_err` rising on the first character after a read. A transmit value that was latched too late shows up only on the character after a mid-character write.

// File: rtl/spi_tgt_pkg.sv
// Shared types for the SPI target port.
// Assumes: configuration inputs are held stable during a character.
package spi_tgt_pkg;
    typedef struct packed {
        logic four_pin;
        logic msb_first;
        logic char7;
        logic cpol;
        logic cpha;
    } spi_cfg_t;
endpackage

// File: rtl/spi_tgt_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: STAGES >= 2; each bit is treated independently.
module spi_tgt_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_shift.sv
// Bit engine: finds serial-clock edges in synchronized samples, captures
// input bits, selects the output bit and reports completed characters.
// Assumes: the local clock is >= 4x the serial clock; inputs are already synchronized.
module spi_tgt_shift
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  spi_cfg_t          cfg,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              ste_s,
    input  logic [DATA_W-1:0] tx_buf,
    input  logic              tx_full,
    output logic              tx_take,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              miso,
    output logic              miso_oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int PR_W  = $clog2(SYNC_STAGES + 1);

    logic [CNT_W-1:0]  rcnt, tptr, len, rcnt_inc, rpos, tpos;
    logic [DATA_W-1:0] rx_sh, tx_char, base;
    logic [PR_W-1:0]   prime_cnt;
    logic              sclk_d, in_char, primed, active;
    logic              edge_seen, lead, trail, samp, shft;

    assign len      = cfg.char7 ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
    assign active   = (!cfg.four_pin || !ste_s) && !sw_rst;
    assign primed   = (prime_cnt == PR_W'(SYNC_STAGES));
    assign edge_seen = primed && (sclk_s != sclk_d);
    assign lead     = edge_seen && (sclk_s != cfg.cpol);
    assign trail    = edge_seen && (sclk_s == cfg.cpol);
    assign samp     = cfg.cpha ? trail : lead;
    assign shft     = cfg.cpha ? lead : trail;
    assign rcnt_inc = rcnt + CNT_W'(1);
    assign rpos     = cfg.msb_first ? (len - rcnt - CNT_W'(1)) : rcnt;
    assign tpos     = cfg.msb_first ? (len - tptr - CNT_W'(1)) : tptr;

    // Build the partially received word with the current input bit inserted.
    always_comb begin
        base    = (rcnt == '0) ? '0 : rx_sh;
        rx_word = base;
        for (int i = 0; i < DATA_W; i++)
            if (CNT_W'(i) == rpos) rx_word[i] = mosi_s;
    end

    // Pick the output bit the controller will sample next.
    always_comb begin
        miso = 1'b0;
        for (int i = 0; i < DATA_W; i++)
            if (CNT_W'(i) == tpos) miso = tx_char[i];
    end

    assign miso_oe = active;
    assign rx_push = active && samp && (rcnt_inc == len);
    assign tx_take = tx_full && !in_char && (rcnt == '0) && !sw_rst;

    // Wait for the synchronizer to flush before trusting edges.
    always_ff @(posedge clk) begin
        if (!rst_n)       prime_cnt <= '0;
        else if (!primed) prime_cnt <= prime_cnt + PR_W'(1);
    end

    // Track the serial clock and the bit counters of the current character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            rcnt    <= '0;
            tptr    <= '0;
            in_char <= 1'b0;
            rx_sh   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (!active) begin
                rcnt    <= '0;
                tptr    <= '0;
                in_char <= 1'b0;
            end else if (samp) begin
                rx_sh   <= rx_word;
                in_char <= 1'b1;
                if (rcnt_inc != len) begin
                    rcnt <= rcnt_inc;
                end else if (cfg.cpha) begin
                    rcnt    <= '0;
                    tptr    <= '0;
                    in_char <= 1'b0;
                end else begin
                    rcnt <= len;
                end
            end else if (shft) begin
                if (rcnt == len) begin
                    rcnt    <= '0;
                    tptr    <= '0;
                    in_char <= 1'b0;
                end else begin
                    if (in_char) tptr <= tptr + CNT_W'(1);
                    in_char <= 1'b1;
                end
            end
        end
    end

    // Latch the next transmit character between characters only.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_char <= '0;
        else if (tx_take) tx_char <= tx_buf;
    end
endmodule

// File: rtl/spi_tgt_host.sv
// Host-side buffers and flags: transmit holding buffer, receive buffer,
// overrun detection, interrupt enables and requests.
// Assumes: rx_rd and tx_wr are single-cycle strobes.
module spi_tgt_host #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              ie_wr,
    input  logic              ie_rx_d,
    input  logic              ie_tx_d,
    input  logic              tx_take,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_word,
    output logic [DATA_W-1:0] tx_buf,
    output logic              tx_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_ready,
    output logic              ovr_err,
    output logic              irq_rx,
    output logic              irq_tx
);
    logic ie_rx, ie_tx;

    // Transmit holding buffer and its occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else if (sw_rst) begin
            tx_full <= 1'b0;
        end else if (tx_wr) begin
            tx_buf  <= tx_data;
            tx_full <= 1'b1;
        end else if (tx_take) begin
            tx_full <= 1'b0;
        end
    end

    // Receive buffer, ready flag and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            if (!rst_n) rx_data <= '0;
            rx_ready <= 1'b0;
            ovr_err  <= 1'b0;
        end else if (rx_push) begin
            rx_data  <= rx_word;
            rx_ready <= 1'b1;
            ovr_err  <= rx_ready && !rx_rd;
        end else if (rx_rd) begin
            rx_ready <= 1'b0;
            ovr_err  <= 1'b0;
        end
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            ie_rx <= 1'b0;
            ie_tx <= 1'b0;
        end else if (ie_wr) begin
            ie_rx <= ie_rx_d;
            ie_tx <= ie_tx_d;
        end
    end

    assign tx_ready = !tx_full;
    assign irq_rx   = rx_ready && ie_rx;
    assign irq_tx   = tx_ready && ie_tx;
endmodule

// File: rtl/spi_target_ovr.sv
// SPI target port top: synchronizes the serial pins, runs the bit engine and
// exposes the host buffers and flags.
// Assumes: clk is at least 4x the serial clock; configuration changes under sw_rst.
module spi_target_ovr
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              four_pin,
    input  logic              msb_first,
    input  logic              char7,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              ie_wr,
    input  logic              ie_rx_d,
    input  logic              ie_tx_d,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              ste_n,
    output logic              miso,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_ready,
    output logic              ovr_err,
    output logic              irq_rx,
    output logic              irq_tx
);
    spi_cfg_t          cfg;
    logic [2:0]        pins_s;
    logic              sclk_s, mosi_s, ste_s;
    logic [DATA_W-1:0] tx_buf, rx_word;
    logic              tx_full, tx_take, rx_push;

    assign cfg = '{four_pin: four_pin, msb_first: msb_first, char7: char7,
                   cpol: cpol, cpha: cpha};

    spi_tgt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({ste_n, mosi, sclk}), .q(pins_s)
    );
    assign {ste_s, mosi_s, sclk_s} = pins_s;

    spi_tgt_shift #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) shift_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg(cfg),
        .sclk_s(sclk_s), .mosi_s(mosi_s), .ste_s(ste_s),
        .tx_buf(tx_buf), .tx_full(tx_full), .tx_take(tx_take),
        .rx_push(rx_push), .rx_word(rx_word), .miso(miso), .miso_oe(miso_oe)
    );

    spi_tgt_host #(.DATA_W(DATA_W)) host_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .ie_wr(ie_wr), .ie_rx_d(ie_rx_d), .ie_tx_d(ie_tx_d),
        .tx_take(tx_take), .rx_push(rx_push), .rx_word(rx_word),
        .tx_buf(tx_buf), .tx_full(tx_full), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_ready(tx_ready), .ovr_err(ovr_err),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );
endmodule

// File: rtl/spi_tgt_chk.sv
// Property checker for the SPI target port, bound to the top module.
// Assumes: sees host strobes, flags and the internal completion pulse.
module spi_tgt_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              four_pin,
    input logic              char7,
    input logic              tx_wr,
    input logic              rx_rd,
    input logic              rx_push,
    input logic              ste_s,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ready,
    input logic              tx_ready,
    input logic              ovr_err,
    input logic              irq_rx,
    input logic              irq_tx
);
    // R5
    overrun_on_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_ready && !rx_rd && !sw_rst) |=> ovr_err);
    // R5
    ovr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err |-> rx_ready);
    // R4
    read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_push && !sw_rst) |=> (!rx_ready && !ovr_err));
    // R10
    soft_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (tx_ready && !rx_ready && !ovr_err && !irq_rx && !irq_tx));
    // R6
    tx_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !sw_rst) |=> !tx_ready);
    // R3
    seven_bit_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && char7) |=> !rx_data[DATA_W-1]);
    // R8
    deselected_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (four_pin && ste_s && !rx_ready) |=> !rx_ready);
    // R11
    rx_irq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_ready);
endmodule

bind spi_target_ovr spi_tgt_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .four_pin(four_pin),
    .char7(char7), .tx_wr(tx_wr), .rx_rd(rx_rd), .rx_push(rx_push),
    .ste_s(ste_s), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .ovr_err(ovr_err), .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/spi_target_ovr_tb_top.sv
// Bench: bit-banged controller model, random and directed characters.
module spi_target_ovr_tb_top;
    localparam int DW   = 8;
    localparam int HALF = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, sw_rst, four_pin, msb_first, char7, cpol, cpha;
    logic tx_wr, rx_rd, ie_wr, ie_rx_d, ie_tx_d, sclk, mosi, ste_n;
    logic [DW-1:0] tx_data, rx_data;
    logic miso, miso_oe, rx_ready, tx_ready, ovr_err, irq_rx, irq_tx;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    spi_target_ovr #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .four_pin(four_pin),
        .msb_first(msb_first), .char7(char7), .cpol(cpol), .cpha(cpha),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .ie_wr(ie_wr),
        .ie_rx_d(ie_rx_d), .ie_tx_d(ie_tx_d), .sclk(sclk), .mosi(mosi),
        .ste_n(ste_n), .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_ready(tx_ready), .ovr_err(ovr_err),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fmt(input logic [7:0] v);
        return char7 ? {1'b0, v[6:0]} : v;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tx(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd_rx();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic set_ie(input logic r, input logic t);
        ie_rx_d = r; ie_tx_d = t; ie_wr = 1'b1; @(negedge clk); ie_wr = 1'b0;
    endtask

    task automatic set_cfg(input logic f, input logic m, input logic s7,
                           input logic p, input logic h);
        sw_rst = 1'b1;
        four_pin = f; msb_first = m; char7 = s7; cpol = p; cpha = h;
        sclk = p; ste_n = 1'b1;
        cyc(6);
        sw_rst = 1'b0;
        cyc(2);
    endtask

    // Controller model: clocks nbits bits, returns what it sampled on miso.
    task automatic xfer(input logic [7:0] mo, input int nbits, input bit late,
                        input logic [7:0] lv, output logic [7:0] got);
        int len;
        len = char7 ? 7 : 8;
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            int b;
            b = msb_first ? (len - 1 - i) : i;
            if (!cpha) begin
                mosi = mo[b];
                cyc(HALF);
                got[b] = miso;
                sclk = ~cpol;
                if (late && i == 0) begin
                    cyc(3); wr_tx(lv);
                    chk("R6 tx_ready low mid-char", tx_ready, 0);
                    cyc(HALF - 4);
                end else cyc(HALF);
                sclk = cpol;
            end else begin
                sclk = ~cpol;
                mosi = mo[b];
                if (late && i == 0) begin
                    cyc(3); wr_tx(lv);
                    chk("R6 tx_ready low mid-char", tx_ready, 0);
                    cyc(HALF - 4);
                end else cyc(HALF);
                got[b] = miso;
                sclk = cpol;
                cyc(HALF);
            end
        end
        cyc(8);
    endtask

    function automatic int clen();
        return char7 ? 7 : 8;
    endfunction

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, t, m, t2;
        void'($urandom(32'd5150));
        rst_n = 0; sw_rst = 0; four_pin = 1; msb_first = 0; char7 = 0;
        cpol = 0; cpha = 0; tx_wr = 0; rx_rd = 0; ie_wr = 0; ie_rx_d = 0;
        ie_tx_d = 0; sclk = 0; mosi = 0; ste_n = 1; tx_data = '0;
        cyc(5); rst_n = 1; cyc(6);

        // R12 reset state
        chk("R12 tx_ready", tx_ready, 1);
        chk("R12 rx_ready", rx_ready, 0);
        chk("R12 ovr_err", ovr_err, 0);
        chk("R12 miso_oe", miso_oe, 0);
        chk("R12 irqs", {irq_rx, irq_tx}, 0);

        // R11 transmit interrupt follows tx_ready
        set_ie(1'b0, 1'b1);
        chk("R11 irq_tx", irq_tx, 1);
        chk("R11 irq_rx", irq_rx, 0);

        // Random characters over all format options
        for (int it = 0; it < 24; it++) begin
            logic f, mf, s7, p, h;
            f = 1'($urandom_range(0, 1)); mf = 1'($urandom_range(0, 1));
            s7 = 1'($urandom_range(0, 1)); p = 1'($urandom_range(0, 1));
            h = 1'($urandom_range(0, 1));
            set_cfg(f, mf, s7, p, h);
            t = 8'($urandom); m = 8'($urandom);
            wr_tx(t); cyc(3);
            chk("R6 buffer taken while idle", tx_ready, 1);
            if (f) ste_n = 1'b0;
            cyc(4);
            xfer(m, clen(), 0, 8'h00, got);
            chk("R1/R2/R3 miso character", got, fmt(t));
            chk("R1/R2/R3 rx_data", rx_data, fmt(m));
            chk("R4 rx_ready set", rx_ready, 1);
            chk("R5 no overrun single", ovr_err, 0);
            rd_rx();
            chk("R4 rx_ready cleared", rx_ready, 0);
            ste_n = 1'b1; cyc(4);
        end

        // R5 overrun keeps newest, cleared by read; R11 receive interrupt
        set_cfg(1, 1, 0, 0, 0);
        set_ie(1'b1, 1'b0);
        ste_n = 0; cyc(4);
        xfer(8'h3C, 8, 0, 8'h00, got);
        chk("R11 irq_rx", irq_rx, 1);
        xfer(8'hC5, 8, 0, 8'h00, got);
        chk("R5 ovr_err set", ovr_err, 1);
        chk("R5 newest kept", rx_data, 8'hC5);
        rd_rx();
        chk("R5 ovr_err cleared by read", ovr_err, 0);
        chk("R4 ready cleared", rx_ready, 0);

        // R7 retransmit without a new write
        wr_tx(8'h96); cyc(3);
        xfer(8'h00, 8, 0, 8'h00, got);
        chk("R7 first send", got, 8'h96);
        xfer(8'h00, 8, 0, 8'h00, got);
        chk("R7 repeated send", got, 8'h96);
        rd_rx();

        // R6 write after first edge goes to the following character (both phases)
        for (int ph = 0; ph < 2; ph++) begin
            set_cfg(1, 0, 0, 1, 1'(ph));
            ste_n = 0; cyc(4);
            t = 8'($urandom); t2 = ~t;
            wr_tx(t); cyc(3);
            xfer(8'h11, 8, 1, t2, got);
            chk("R6 current char keeps old data", got, t);
            chk("R6 tx_ready after char", tx_ready, 1);
            xfer(8'h22, 8, 0, 8'h00, got);
            chk("R6 late data in next char", got, t2);
            rd_rx();
        end

        // R8 deselected: no capture, output disabled
        set_cfg(1, 0, 0, 0, 0);
        chk("R8 miso_oe off", miso_oe, 0);
        xfer(8'hA5, 8, 0, 8'h00, got);
        chk("R8 nothing received", rx_ready, 0);
        // R8 partial character discarded on deselect
        ste_n = 0; cyc(4);
        xfer(8'hFF, 3, 0, 8'h00, got);
        ste_n = 1; cyc(4);
        chk("R8 partial not delivered", rx_ready, 0);
        ste_n = 0; cyc(4);
        xfer(8'h5A, 8, 0, 8'h00, got);
        chk("R8 fresh char after discard", rx_data, 8'h5A);
        chk("R8 ready after fresh char", rx_ready, 1);
        rd_rx(); ste_n = 1;

        // R9 three-wire: select ignored
        set_cfg(0, 1, 0, 1, 0);
        ste_n = 1; cyc(4);
        chk("R9 miso_oe on", miso_oe, 1);
        wr_tx(8'h6B); cyc(3);
        xfer(8'hE7, 8, 0, 8'h00, got);
        chk("R9 rx with ste_n high", rx_data, 8'hE7);
        chk("R9 tx with ste_n high", got, 8'h6B);

        // R10 soft reset clears flags and enables
        xfer(8'h01, 8, 0, 8'h00, got);
        set_ie(1'b1, 1'b1);
        chk("R10 precondition overrun", ovr_err, 1);
        sw_rst = 1; cyc(2); sw_rst = 0; cyc(1);
        chk("R10 rx_ready cleared", rx_ready, 0);
        chk("R10 ovr_err cleared", ovr_err, 0);
        chk("R10 tx_ready set", tx_ready, 1);
        chk("R10 enables cleared", {irq_rx, irq_tx}, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule